// File: doc/BRIEF.md
# Payload Window Gate

This block watches a byte stream that carries IPv4 packets with TCP segments and raises a gating enable for exactly the payload bytes of each packet. A downstream content filter can then look only at payload data and skip the protocol headers. The first byte of every packet is marked by a start flag, and only bytes with the valid strobe high count as stream bytes.

The block reads the 16-bit total length field, most significant byte first, from a fixed offset in the IP header. It subtracts the combined header size to get the payload length. Three down-counters then run one after another. The first runs from the start byte through the low byte of the length field. The second runs over the rest of the combined header. The third runs over the payload. The header size is fixed by a parameter at 40 bytes (20 for IP and 20 for TCP), because options are not handled.

Each accepted byte is copied to a one-stage output register, and the enable is registered with it. The enable therefore qualifies the byte shown beside it on the output.

Top module: `pg_payload_gate`

## Requirements
- R1: While reset is asserted and after it is released, `pay_en` and `out_valid` are 0 and `pay_len` is 0 until stream bytes arrive.
- R2: The byte accepted with `in_sop` high is offset 0. Offset 2 is the high byte and offset 3 the low byte of the total length T. `pay_len` becomes T-40 (0 if T is 40 or less) in the output cycle of the offset-3 byte, and reads 0 in the output cycles of offsets 0 to 2.
- R3: `pay_en` is 1 in the output cycle of every byte at offsets 40 through T-1 and 0 for offsets 0 through 39, so it is high for exactly T-40 bytes per packet.
- R4: When T is 40 or less, `pay_en` never goes high for that packet.
- R5: Cycles with `in_valid` low advance no counter, produce `out_valid` 0 and `pay_en` 0, and their `in_sop` and `in_byte` values have no effect on the sequence.
- R6: A byte accepted with `in_sop` high restarts the whole sequence at offset 0 from any state, including in the middle of a payload.
- R7: Bytes that arrive after the payload has ended and before the next start byte never raise `pay_en`.
- R8: `out_valid` and `out_byte` equal `in_valid` and `in_byte` one clock later, and `pay_en` is high only when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte is present this cycle |
| in_sop | input | 1 | Byte is the first byte of a packet (with in_valid) |
| out_byte | output | 8 | Registered copy of the accepted byte |
| out_valid | output | 1 | Registered copy of in_valid |
| pay_en | output | 1 | Registered payload enable, aligned with out_byte |
| pay_len | output | 16 | Payload length computed from the total length field |

## Verification
The bench builds the block with its default parameters: a 40-byte header, the length field at offsets 2 and 3, and a 16-bit length. These values make every boundary reachable in a short run. Lengths of 20, 40 and 41 cover the saturating subtraction and a one-byte payload. A total length of 0xFFFF exercises the high byte of the field across a very long payload. Truncated packets, gapped strobes carrying a stray start flag, and surplus trailing bytes cover the restart and ignore paths.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEN  = 2'd1,
        PH_HDR  = 2'd2,
        PH_PAY  = 2'd3
    } phase_t;

    localparam int CNT_NUM = 3;
    localparam int CNT_LEN = 0;
    localparam int CNT_HDR = 1;
    localparam int CNT_PAY = 2;

endpackage

// File: rtl/pg_len_calc.sv
module pg_len_calc #(
    parameter int LEN_W     = 16,
    parameter int HDR_BYTES = 40
) (
    input  logic [LEN_W-1:0] total_len,
    output logic [LEN_W-1:0] pay_len
);
    localparam logic [LEN_W-1:0] HDR_V = LEN_W'(HDR_BYTES);

    always_comb begin
        if (total_len > HDR_V) begin
            pay_len = total_len - HDR_V;
        end else begin
            pay_len = '0;
        end
    end
endmodule

// File: rtl/pg_span_ctr.sv
module pg_span_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pg_payload_gate.sv
module pg_payload_gate
    import pg_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 16,
    parameter int IP_HDR     = 20,
    parameter int TCP_HDR    = 20,
    parameter int LEN_HI_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_sop,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_valid,
    output logic              pay_en,
    output logic [LEN_W-1:0]  pay_len
);
    localparam int HDR_BYTES = IP_HDR + TCP_HDR;
    localparam int LEN_SPAN  = LEN_HI_OFS + 1;
    localparam int HDR_REST  = HDR_BYTES - LEN_HI_OFS - 2;
    localparam logic [LEN_W-1:0] ONE_V = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO_V = LEN_W'(2);

    typedef struct packed {
        phase_t              phase;
        logic [DATA_W-1:0]   len_hi;
        logic [LEN_W-1:0]    plen;
        logic                en;
        logic                ovld;
        logic [DATA_W-1:0]   obyte;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic              ld     [CNT_NUM];
    logic [LEN_W-1:0]  ld_val [CNT_NUM];
    logic              dc     [CNT_NUM];
    logic [LEN_W-1:0]  cnt    [CNT_NUM];
    logic [LEN_W-1:0]  calc_len;

    pg_len_calc #(
        .LEN_W     (LEN_W),
        .HDR_BYTES (HDR_BYTES)
    ) u_calc (
        .total_len ({st_q.len_hi, in_byte}),
        .pay_len   (calc_len)
    );

    for (genvar gi = 0; gi < CNT_NUM; gi++) begin : g_ctr
        pg_span_ctr #(.W(LEN_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld[gi]),
            .load_val (ld_val[gi]),
            .dec      (dc[gi]),
            .cnt      (cnt[gi])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.en    = 1'b0;
        st_d.ovld  = in_valid;
        if (in_valid) begin
            st_d.obyte = in_byte;
        end
        for (int i = 0; i < CNT_NUM; i++) begin
            ld[i]     = 1'b0;
            ld_val[i] = '0;
            dc[i]     = 1'b0;
        end

        if (in_valid && in_sop) begin
            st_d.phase       = PH_LEN;
            st_d.plen        = '0;
            ld[CNT_LEN]      = 1'b1;
            ld_val[CNT_LEN]  = LEN_W'(LEN_SPAN);
        end else if (in_valid) begin
            unique case (st_q.phase)
                PH_LEN: begin
                    dc[CNT_LEN] = 1'b1;
                    if (cnt[CNT_LEN] == TWO_V) begin
                        st_d.len_hi = in_byte;
                    end
                    if (cnt[CNT_LEN] == ONE_V) begin
                        st_d.plen       = calc_len;
                        st_d.phase      = PH_HDR;
                        ld[CNT_HDR]     = 1'b1;
                        ld_val[CNT_HDR] = LEN_W'(HDR_REST);
                    end
                end
                PH_HDR: begin
                    dc[CNT_HDR] = 1'b1;
                    if (cnt[CNT_HDR] == ONE_V) begin
                        if (st_q.plen != '0) begin
                            st_d.phase      = PH_PAY;
                            ld[CNT_PAY]     = 1'b1;
                            ld_val[CNT_PAY] = st_q.plen;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                PH_PAY: begin
                    dc[CNT_PAY] = 1'b1;
                    st_d.en     = 1'b1;
                    if (cnt[CNT_PAY] == ONE_V) begin
                        st_d.phase = PH_IDLE;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, len_hi: '0, plen: '0, en: 1'b0,
                      ovld: 1'b0, obyte: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte  = st_q.obyte;
    assign out_valid = st_q.ovld;
    assign pay_en    = st_q.en;
    assign pay_len   = st_q.plen;
endmodule

// File: rtl/pg_payload_gate_chk.sv
module pg_payload_gate_chk #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_byte,
    input logic              in_valid,
    input logic              in_sop,
    input logic [DATA_W-1:0] out_byte,
    input logic              out_valid,
    input logic              pay_en,
    input logic [LEN_W-1:0]  pay_len
);
    logic           armed;
    logic [LEN_W:0] en_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            en_seen <= '0;
        end else begin
            armed <= 1'b1;
            if (in_valid && in_sop) begin
                en_seen <= '0;
            end else if (pay_en) begin
                en_seen <= en_seen + 1'b1;
            end
        end
    end

    assert_en_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_en |-> out_valid);

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    assert_byte_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid)) |-> (out_byte == $past(in_byte)));

    assert_idle_keeps_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_valid) |-> (pay_len == $past(pay_len)));

    assert_sop_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid && in_sop)) |-> (!pay_en && pay_len == '0));

    assert_short_no_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pay_en |-> (pay_len != '0));

    assert_en_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pay_en |-> (en_seen < {1'b0, pay_len}));
endmodule

bind pg_payload_gate pg_payload_gate_chk #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_byte   (in_byte),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .pay_en    (pay_en),
    .pay_len   (pay_len)
);

// File: tb/sim_pg_payload_gate.sv
`timescale 1ns/1ps
module sim_pg_payload_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  out_byte;
    logic        out_valid;
    logic        pay_en;
    logic [15:0] pay_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [7:0]  b;
        logic        en;
        logic [15:0] len;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    pg_payload_gate u0 (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .in_sop(in_sop), .out_byte(out_byte), .out_valid(out_valid),
        .pay_en(pay_en), .pay_len(pay_len)
    );

    function automatic logic [15:0] sat_len(int t);
        return (t > 40) ? 16'(t - 40) : 16'd0;
    endfunction

    // Driver: sends nbytes of a packet whose length field is t.
    // gap > 0 inserts an idle cycle with a stray start flag (R5).
    task automatic send_pkt(int t, int nbytes, int gap);
        for (int k = 0; k < nbytes; k++) begin
            exp_t e;
            logic [7:0] b;
            if (gap > 0 && (k % gap) == 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sop   = 1'b1;
                in_byte  = 8'hC3;
            end
            if (k == 2)      b = 8'(t >> 8);
            else if (k == 3) b = 8'(t);
            else             b = 8'(k) ^ 8'h5A;
            e.b   = b;
            e.en  = (k >= 40) && (k < t);     // R3, R7
            e.len = (k >= 3) ? sat_len(t) : 16'd0;  // R2
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (k == 0);
            in_byte  = b;
            sb.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    // Monitor: compares each output byte with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8: output byte with nothing expected, got %h exp none", out_byte);
                end else begin
                    e = sb.pop_front();
                    checks++;
                    if (pay_en !== e.en) begin
                        fails++;
                        $display("FAIL R3/R4/R6/R7: pay_en got %b exp %b", pay_en, e.en);
                    end
                    checks++;
                    if (pay_len !== e.len) begin
                        fails++;
                        $display("FAIL R2: pay_len got %0d exp %0d", pay_len, e.len);
                    end
                    checks++;
                    if (out_byte !== e.b) begin
                        fails++;
                        $display("FAIL R8: out_byte got %h exp %h", out_byte, e.b);
                    end
                end
            end else begin
                checks++;
                if (pay_en !== 1'b0) begin
                    fails++;
                    $display("FAIL R5: pay_en got %b exp 0 on idle output", pay_en);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pay_en !== 1'b0 || out_valid !== 1'b0 || pay_len !== 16'd0) begin
            fails++;
            $display("FAIL R1: reset en=%b vld=%b len=%0d exp 0 0 0", pay_en, out_valid, pay_len);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pay_en !== 1'b0 || out_valid !== 1'b0 || pay_len !== 16'd0) begin
            fails++;
            $display("FAIL R1: after reset en=%b vld=%b len=%0d exp 0 0 0", pay_en, out_valid, pay_len);
        end

        send_pkt(63, 63, 0);      // R3: 23 payload bytes
        send_pkt(40, 40, 0);      // R4: boundary, no payload
        send_pkt(20, 44, 0);      // R4: short length, extra bytes
        send_pkt(41, 41, 0);      // R3: single payload byte
        send_pkt(100, 100, 3);    // R5: gaps with stray start flag
        send_pkt(50, 58, 0);      // R7: trailing bytes after payload
        send_pkt(200, 30, 0);     // R6: truncated inside header
        send_pkt(120, 70, 0);     // R6: truncated inside payload
        send_pkt(45, 45, 2);      // R6/R5: restart then gapped packet
        send_pkt(16'h0FA0, 16'h0FA0, 0); // R2: high byte in use
        send_pkt(16'hFFFF, 16'hFFFF, 0); // R2/R3: largest length
        repeat (4) @(negedge clk);

        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d output bytes missing, exp 0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule